// File: doc/BRIEF.md
# Externally Triggered Down-Count Timer

This block is a down-counting timer that waits for a falling edge on an external trigger pin before it starts. A small register write port sets the initial count, the prescaler value, the trigger mode, the single-pass or continuous choice and the enable bit. Once triggered, the timer loads its initial count and decrements on prescaled ticks. It emits a one-cycle interrupt pulse at end of count.

The trigger pin is synchronized and edge-detected inside the block. In one-shot mode only the first falling edge after enabling starts the count, and later edges are ignored. In retriggerable mode every falling edge reloads the count and restarts the interval, so the interrupt fires only when the pin stays quiet for a full interval. In single-pass operation, end of count clears the enable bit, and the timer then ignores the pin until software sets enable again. In continuous operation the count reloads at every end of count until software clears enable.

The write port is a plain single-cycle strobe with no back-pressure: a write is accepted on every clock edge where `wr_en` is high. All other pins are plain control and status signals.

Top module: `trig_timer`

## Requirements
- R1: After reset, `irq`, `count_val`, `enable_q` and `running` are all 0.
- R2: A write to address 0 sets the control fields from `wr_data`: bit 0 is enable, bit 1 is continuous, bits 3:2 are mode. A write to address 1 sets the prescaler value N from bits 3:0. A write to address 2 sets the initial count from bits 7:0. A write to address 3 changes nothing.
- R3: When mode is 2'b10 and the timer is enabled and idle, a falling edge on `trig_n` loads the initial count into `count_val` and sets `running`. The load takes effect at the third rising clock edge at which the pin is sampled low.
- R4: In mode 2'b10, falling edges that arrive while the timer is running do not reload the count or change the time of the interrupt.
- R5: In mode 2'b11, every falling edge while enabled reloads the count and restarts the interval. `irq` fires only after a full interval passes with no falling edge.
- R6: Once running, the count decrements by one every 8*(N+1) clock cycles, where the first tick comes 8*(N+1) cycles after the load.
- R7: A tick that finds a count of 1 is end of count. `irq` is high for exactly the one clock cycle that follows that tick.
- R8: In single-pass operation (continuous = 0), end of count clears `enable_q` and `running` and leaves `count_val` at 0. Later falling edges are ignored until enable is written to 1 again.
- R9: In continuous operation, end of count reloads the initial count and counting goes on. Writing enable to 0 stops the count at once, clears `running`, and no interrupt follows.
- R10: While enabled but not yet triggered, `count_val` holds its value and `running` stays 0.
- R11: With mode 2'b00 or 2'b01, falling edges never start the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| trig_n | input | 1 | Asynchronous trigger pin, acts on falling edges |
| irq | output | 1 | One-cycle end-of-count interrupt pulse |
| count_val | output | 8 | Current counter value |
| enable_q | output | 1 | Current enable bit |
| running | output | 1 | High while the timer has been triggered and is counting |

## Verification
The assertions assume that the trigger pin, once synchronized, holds each level for at least one clock. They also assume that a tick interval is never shorter than the fixed divide-by-8, so that the interrupt pulse cannot repeat on the next cycle. They further assume that software does not rewrite the control register in the same cycle as a single-pass end of count. The stimulus meets these assumptions in three ways: it drives the pin only at falling clock edges and holds each level for several cycles, it uses initial counts of at least 1, and it issues its control writes only while the timer is idle or well inside an interval. A behavioural model in the bench follows the pin, the registers and the interval timing, and the design is compared with it every cycle.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_NONE0   = 2'b00,
    MODE_NONE1   = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_RETRIG  = 2'b11
  } tmode_e;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRESC = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_INIT  = 2'd2;
endpackage

// File: rtl/tt_regs.sv
module tt_regs
  import trig_timer_pkg::*;
#(
  parameter int CW = 8,
  parameter int PW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_enable,
  output logic              enable,
  output logic              cont,
  output tmode_e            mode,
  output logic [PW-1:0]     presc,
  output logic [CW-1:0]     init
);
  logic ctrl_wr;
  logic unused_hi;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign unused_hi = ^wr_data[DATA_W-1:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      cont   <= 1'b0;
      mode   <= MODE_NONE0;
      presc  <= '0;
      init   <= '0;
    end else begin
      if (ctrl_wr) begin
        enable <= wr_data[0];
        cont   <= wr_data[1];
        mode   <= tmode_e'(wr_data[3:2]);
      end else if (clr_enable) begin
        enable <= 1'b0;
      end
      if (wr_en && wr_addr == ADDR_PRESC) presc <= wr_data[PW-1:0];
      if (wr_en && wr_addr == ADDR_INIT)  init  <= wr_data[CW-1:0];
    end
  end

  AST_EOC_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_enable && !ctrl_wr) |=> !enable); // R8
endmodule

// File: rtl/tt_sync.sv
module tt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b1;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];

  assign fall = prev_q && !sync_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R3
endmodule

// File: rtl/tt_prescale.sv
module tt_prescale #(
  parameter int FIXED_DIV = 8,
  parameter int PW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [PW-1:0] presc,
  output logic          tick
);
  localparam int DIV_W = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FIXED_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [PW-1:0]    pre_q;
  logic             div_wrap;

  assign div_wrap = (div_q == DIV_LAST);
  assign tick     = run && div_wrap && (pre_q >= presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (load) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (run) begin
      div_q <= div_wrap ? '0 : div_q + 1'b1;
      if (div_wrap) pre_q <= (pre_q >= presc) ? '0 : pre_q + 1'b1;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6
endmodule

// File: rtl/tt_core.sv
module tt_core
  import trig_timer_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cont,
  input  tmode_e        mode,
  input  logic [CW-1:0] init,
  input  logic          fall,
  input  logic          tick,
  output logic          load,
  output logic          run,
  output logic          clr_enable,
  output logic [CW-1:0] cnt,
  output logic          running,
  output logic          irq
);
  logic may_trigger;
  logic eoc;

  assign may_trigger = enable &&
                       ((mode == MODE_ONESHOT && !running) || mode == MODE_RETRIG);
  assign load        = may_trigger && fall;
  assign run         = running && enable;
  assign eoc         = run && tick && !load && (cnt <= CW'(1));
  assign clr_enable  = eoc && !cont;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= eoc;
      if (!enable) begin
        running <= 1'b0;
      end else if (load) begin
        cnt     <= init;
        running <= 1'b1;
      end else if (eoc) begin
        if (cont) begin
          cnt <= init;
        end else begin
          cnt     <= '0;
          running <= 1'b0;
        end
      end else if (running && tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_IRQ_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cnt) <= CW'(1))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !fall) |=> $stable(cnt)); // R10
  AST_CLEAR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !running); // R9
  AST_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && (mode == MODE_NONE0 || mode == MODE_NONE1)) |=> !running); // R11
endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int CW          = 8,
  parameter int PW          = 4,
  parameter int FIXED_DIV   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              trig_n,
  output logic              irq,
  output logic [CW-1:0]     count_val,
  output logic              enable_q,
  output logic              running
);
  logic          enable, cont, fall, tick, load, run, clr_enable;
  tmode_e        mode;
  logic [PW-1:0] presc;
  logic [CW-1:0] init;

  tt_regs #(.CW(CW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clr_enable(clr_enable), .enable(enable),
    .cont(cont), .mode(mode), .presc(presc), .init(init)
  );

  tt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_n), .fall(fall)
  );

  tt_prescale #(.FIXED_DIV(FIXED_DIV), .PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run),
    .presc(presc), .tick(tick)
  );

  tt_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cont(cont), .mode(mode),
    .init(init), .fall(fall), .tick(tick), .load(load), .run(run),
    .clr_enable(clr_enable), .cnt(count_val), .running(running), .irq(irq)
  );

  assign enable_q = enable;
endmodule

// File: tb/trig_timer_test.sv
module trig_timer_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic       trig_n = 1;
  logic       irq, enable_q, running;
  logic [7:0] count_val;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;
  int cyc = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_en = 0, m_cont = 0, m_mode = 0, m_presc = 0, m_init = 0;
  int m_run = 0, m_cnt = 0, m_irq = 0, m_left = 0;
  int p1 = 1, p2 = 1, p3 = 1;

  trig_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_n(trig_n), .irq(irq), .count_val(count_val),
    .enable_q(enable_q), .running(running)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    int fall, load, tick, eoc, ctrl;
    if (rst_n) begin
      fall = (p3 == 1 && p2 == 0);
      load = m_en && fall && ((m_mode == 2 && !m_run) || m_mode == 3);
      tick = 0;
      if (m_run && m_en && !load) begin
        if (m_left == 1) begin tick = 1; m_left = 8 * (m_presc + 1); end
        else m_left = m_left - 1;
      end
      eoc = tick && (m_cnt <= 1);
      m_irq = eoc;
      if (!m_en) m_run = 0;
      else if (load) begin
        m_cnt = m_init; m_run = 1; m_left = 8 * (m_presc + 1);
      end else if (eoc) begin
        if (m_cont) m_cnt = m_init;
        else begin m_cnt = 0; m_run = 0; end
      end else if (tick) m_cnt = m_cnt - 1;
      ctrl = wr_en && wr_addr == 0;
      if (ctrl) begin
        m_en = wr_data[0]; m_cont = wr_data[1]; m_mode = wr_data[3:2];
      end else if (eoc && !m_cont) m_en = 0;
      if (wr_en && wr_addr == 1) m_presc = wr_data[3:0];
      if (wr_en && wr_addr == 2) m_init = wr_data;
      p3 = p2; p2 = p1; p1 = trig_n;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "irq", irq, m_irq);
      check(cur_req, "count_val", count_val, m_cnt);
      check(cur_req, "enable_q", enable_q, m_en);
      check(cur_req, "running", running, m_run);
      if (irq) irq_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); trig_n = 0;
    idle(4);
    trig_n = 1;
  endtask

  // ctrl byte: bit0 enable, bit1 continuous, bits3:2 mode
  function automatic int ctl(input int mode, input int cont, input int en);
    return (mode << 2) | (cont << 1) | en;
  endfunction

  initial begin
    int base, cnt_before;
    idle(3);
    check("R1", "reset irq", irq, 0);
    check("R1", "reset count", count_val, 0);
    check("R1", "reset enable", enable_q, 0);
    check("R1", "reset running", running, 0);
    rst_n = 1;
    idle(2);

    cur_req = "R2";
    wr(1, 0); wr(2, 3);
    wr(3, 8'hFF);
    idle(2);
    check("R2", "addr3 enable", enable_q, 0);
    check("R2", "addr3 count", count_val, 0);

    // one-shot single pass, N=0, count 3
    cur_req = "R3";
    wr(0, ctl(2, 0, 1));
    idle(2);
    @(negedge clk); trig_n = 0;
    idle(2);
    check("R3", "not yet loaded", running, 0);
    idle(1);
    check("R3", "loaded count", count_val, 3);
    check("R3", "running set", running, 1);
    trig_n = 1;
    cur_req = "R4";
    base = irq_seen;
    idle(6); pulse(); idle(4); pulse();
    idle(20);
    check("R4", "one irq despite edges", irq_seen - base, 1);
    cur_req = "R8";
    check("R8", "enable cleared", enable_q, 0);
    check("R8", "count zero", count_val, 0);
    base = irq_seen;
    pulse(); idle(40);
    check("R8", "locked out irq", irq_seen - base, 0);
    check("R8", "locked out running", running, 0);

    // idle hold while enabled and untriggered
    cur_req = "R10";
    wr(2, 5);
    wr(0, ctl(2, 0, 1));
    cnt_before = count_val;
    idle(40);
    check("R10", "count held", count_val, cnt_before);
    check("R10", "not running", running, 0);

    // prescaler N=2, count 2: end of count 48 cycles after load
    cur_req = "R6";
    wr(1, 2); wr(2, 2);
    wr(0, ctl(2, 0, 1));
    base = irq_seen;
    pulse();
    idle(36);
    check("R6", "no irq before 48 cycles", irq_seen - base, 0);
    check("R6", "count after first tick", count_val, 1);
    idle(20);
    cur_req = "R7";
    check("R7", "irq after interval", irq_seen - base, 1);

    // retriggerable single pass, N=0, count 3 (24 cycles)
    cur_req = "R5";
    wr(1, 0); wr(2, 3);
    wr(0, ctl(3, 0, 1));
    base = irq_seen;
    for (int i = 0; i < 5; i++) begin pulse(); idle(12); end
    check("R5", "no irq while retriggered", irq_seen - base, 0);
    check("R5", "still running", running, 1);
    idle(30);
    check("R5", "irq after quiet interval", irq_seen - base, 1);

    // continuous one-shot mode, count 2 (16 cycles)
    cur_req = "R9";
    wr(2, 2);
    wr(0, ctl(2, 1, 1));
    base = irq_seen;
    pulse();
    idle(100);
    check("R9", "repeated irqs", (irq_seen - base >= 5) ? 1 : 0, 1);
    check("R9", "still enabled", enable_q, 1);
    wr(0, ctl(2, 1, 0));
    base = irq_seen;
    idle(40);
    check("R9", "stopped irq", irq_seen - base, 0);
    check("R9", "stopped running", running, 0);

    // modes 00 and 01 never start
    cur_req = "R11";
    base = irq_seen;
    wr(0, ctl(0, 0, 1));
    pulse(); idle(10);
    check("R11", "mode 00 running", running, 0);
    wr(0, ctl(1, 0, 1));
    pulse(); idle(40);
    check("R11", "mode 01 running", running, 0);
    check("R11", "no irq", irq_seen - base, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule